// File: doc/BRIEF.md
# Rotating-Parity Small-Write Controller

This block serves single-block writes to a five-column striped disk array whose parity block moves to a different column on every stripe. A write arrives as a logical block address and one block of data. The block finds the stripe, the data column and the parity column for that address. It then runs a read-modify-write sequence so that the parity of the stripe stays consistent. The new parity is the old parity corrected by the change in the data block, so the other data blocks of the stripe are never read.

Each column is a separate synchronous block memory, and the controller talks to all of them over one shared request bus. The controller raises a per-column request line and holds it until that column answers with a one-cycle acknowledge. Read data is valid in the acknowledge cycle. Only one access is outstanding at any time. The controller is busy for the whole sequence, signals completion with a one-cycle pulse, and ignores write requests while it is busy.

Top module: `rmw_parity_ctrl`

## Requirements
- R1: With C columns (default 5), an address A maps as follows. Stripe s = A / (C-1) and slot k = A mod (C-1). The parity column is (C-1) - (s mod C). The data column is k when k is below the parity column, and k+1 otherwise. Both column accesses use s as the memory address.
- R2: Each accepted write produces exactly four acknowledged memory accesses: two reads (mem_we = 0) followed by two writes (mem_we = 1).
- R3: The four accesses come in a fixed order: read of the data column, read of the parity column, write of the data column, write of the parity column.
- R4: The value written to the parity column equals old data XOR new data XOR old parity. Afterwards the XOR across all columns of every stripe is unchanged, so it is still zero when it started at zero.
- R5: At most one bit of mem_req is high at a time. A request stays asserted, with its address, unchanged until its column's mem_ack arrives, for any memory latency.
- R6: busy is high from the cycle after acceptance until the final acknowledge. done is a single-cycle pulse in the first cycle that busy is low again.
- R7: wr_valid is ignored while busy is high. No access is made for the refused write, and no memory contents change because of it.
- R8: While reset is asserted and directly after it, busy, done and mem_req are all zero.
- R9: After done, the addressed block holds the new data, the stripe's parity block holds the new parity, and no other block has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request, taken when idle |
| wr_lba | input | LBA_W (6) | Logical block address of the write |
| wr_data | input | BLK_W (8) | New block contents |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | NUM_COLS (5) | One-hot access request per column |
| mem_we | output | 1 | 1 = write, 0 = read for the current request |
| mem_addr | output | STRIPE_W (4) | Stripe index used as the column address |
| mem_wdata | output | BLK_W (8) | Write data for the current request |
| mem_ack | input | NUM_COLS (5) | Per-column one-cycle acknowledge |
| mem_rdata | input | NUM_COLS*BLK_W (40) | Per-column read data, column c at bits c*BLK_W upward |

## Verification
The tests write to addresses in stripes where parity sits in the last column, one column in, in column 0, and back in the last column after the rotation wraps. Together they separate a correct slot-skip from an off-by-one on either side of the parity column. Repeated writes to one block, a write of zero, and writes with column latencies that differ from one another and then grow larger show whether the parity is folded from the values actually read. They also show whether each request is held while it waits. A burst of write requests during a busy sequence tells refusal apart from queuing or overwriting. After every write, a full scan of the array checks the stripe XOR and confirms that no stray block changed.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DATA,
      ST_RD_PAR,
      ST_WR_DATA,
      ST_WR_PAR
   } rmw_state_e;

endpackage

// File: rtl/rmw_addr_map.sv
module rmw_addr_map #(
   parameter int NUM_COLS = 5,
   parameter int LBA_W    = 6,
   parameter int STRIPE_W = 4,
   parameter int COL_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LBA_W-1:0]    lba,
   output logic [STRIPE_W-1:0] stripe,
   output logic [COL_W-1:0]    dcol,
   output logic [COL_W-1:0]    pcol
);

   localparam int DATA_COLS = NUM_COLS - 1;
   localparam int SLOT_W    = (DATA_COLS > 1) ? $clog2(DATA_COLS) : 1;
   localparam bit DATA_POW2 = ((DATA_COLS & (DATA_COLS - 1)) == 0);

   logic [LBA_W-1:0] stripe_full;
   logic [COL_W-1:0] slot;
   logic [COL_W-1:0] smod;

   generate
      if (DATA_POW2) begin : g_shift
         assign stripe_full = lba >> SLOT_W;
         assign slot        = COL_W'(lba[SLOT_W-1:0]);
      end else begin : g_divide
         assign stripe_full = LBA_W'(lba / LBA_W'(DATA_COLS));
         assign slot        = COL_W'(lba % LBA_W'(DATA_COLS));
      end
   endgenerate

   assign stripe = STRIPE_W'(stripe_full);
   assign smod   = COL_W'(stripe % STRIPE_W'(NUM_COLS));
   assign pcol   = COL_W'(NUM_COLS - 1) - smod;
   assign dcol   = (slot >= pcol) ? slot + COL_W'(1) : slot;

   // R1
   map_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pcol < COL_W'(NUM_COLS)) && (dcol < COL_W'(NUM_COLS)) && (dcol != pcol));

endmodule

// File: rtl/rmw_parity_acc.sv
module rmw_parity_acc #(
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             fold_en,
   input  logic [BLK_W-1:0] new_data,
   input  logic [BLK_W-1:0] rd_data,
   output logic [BLK_W-1:0] acc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (load_en) begin
         acc <= new_data ^ rd_data;
      end else if (fold_en) begin
         acc <= acc ^ rd_data;
      end
   end

   // R4
   load_fold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && fold_en));

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
   import rmw_pkg::*;
#(
   parameter int NUM_COLS = 5,
   parameter int BLK_W    = 8,
   parameter int STRIPE_W = 4,
   parameter int COL_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [BLK_W-1:0]    wr_data,
   input  logic [STRIPE_W-1:0] map_stripe,
   input  logic [COL_W-1:0]    map_dcol,
   input  logic [COL_W-1:0]    map_pcol,
   input  logic [NUM_COLS-1:0] mem_ack,
   input  logic [BLK_W-1:0]    par_acc,
   output logic [NUM_COLS-1:0] mem_req,
   output logic                mem_we,
   output logic [STRIPE_W-1:0] mem_addr,
   output logic [BLK_W-1:0]    mem_wdata,
   output logic [COL_W-1:0]    sel_col,
   output logic [BLK_W-1:0]    data_q,
   output logic                load_en,
   output logic                fold_en,
   output logic                busy,
   output logic                done
);

   rmw_state_e          st;
   logic [STRIPE_W-1:0] stripe_q;
   logic [COL_W-1:0]    dcol_q;
   logic [COL_W-1:0]    pcol_q;
   logic                ack_hit;

   assign sel_col   = (st == ST_RD_DATA || st == ST_WR_DATA) ? dcol_q : pcol_q;
   assign busy      = (st != ST_IDLE);
   assign ack_hit   = busy && mem_ack[sel_col];
   assign mem_we    = (st == ST_WR_DATA) || (st == ST_WR_PAR);
   assign mem_addr  = stripe_q;
   assign mem_wdata = (st == ST_WR_PAR) ? par_acc : data_q;
   assign load_en   = (st == ST_RD_DATA) && ack_hit;
   assign fold_en   = (st == ST_RD_PAR) && ack_hit;

   always_comb begin
      mem_req = '0;
      if (busy) mem_req[sel_col] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         stripe_q <= '0;
         dcol_q   <= '0;
         pcol_q   <= '0;
         data_q   <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (wr_valid) begin
               stripe_q <= map_stripe;
               dcol_q   <= map_dcol;
               pcol_q   <= map_pcol;
               data_q   <= wr_data;
               st       <= ST_RD_DATA;
            end
            ST_RD_DATA: if (ack_hit) st <= ST_RD_PAR;
            ST_RD_PAR:  if (ack_hit) st <= ST_WR_DATA;
            ST_WR_DATA: if (ack_hit) st <= ST_WR_PAR;
            ST_WR_PAR:  if (ack_hit) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R5
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_req));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mem_req & ~mem_ack)) |=> (mem_req == $past(mem_req)) && (mem_addr == $past(mem_addr)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/rmw_parity_ctrl.sv
module rmw_parity_ctrl #(
   parameter int NUM_COLS = 5,
   parameter int BLK_W    = 8,
   parameter int LBA_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_valid,
   input  logic [LBA_W-1:0]            wr_lba,
   input  logic [BLK_W-1:0]            wr_data,
   output logic                        busy,
   output logic                        done,
   output logic [NUM_COLS-1:0]         mem_req,
   output logic                        mem_we,
   output logic [$clog2(((1 << LBA_W) + NUM_COLS - 2) / (NUM_COLS - 1))-1:0] mem_addr,
   output logic [BLK_W-1:0]            mem_wdata,
   input  logic [NUM_COLS-1:0]         mem_ack,
   input  logic [NUM_COLS*BLK_W-1:0]   mem_rdata
);

   localparam int DATA_COLS = NUM_COLS - 1;
   localparam int STRIPES   = ((1 << LBA_W) + DATA_COLS - 1) / DATA_COLS;
   localparam int STRIPE_W  = $clog2(STRIPES);
   localparam int COL_W     = $clog2(NUM_COLS);

   generate
      if (NUM_COLS < 3) begin : g_bad_cols
         $error("rmw_parity_ctrl: NUM_COLS must be at least 3");
      end
      if (BLK_W < 1) begin : g_bad_blk
         $error("rmw_parity_ctrl: BLK_W must be positive");
      end
      if (STRIPES <= NUM_COLS) begin : g_bad_lba
         $error("rmw_parity_ctrl: LBA_W too small for a full parity rotation");
      end
   endgenerate

   logic [STRIPE_W-1:0] map_stripe;
   logic [COL_W-1:0]    map_dcol;
   logic [COL_W-1:0]    map_pcol;
   logic [COL_W-1:0]    sel_col;
   logic [BLK_W-1:0]    sel_rdata;
   logic [BLK_W-1:0]    par_acc;
   logic [BLK_W-1:0]    data_q;
   logic                load_en;
   logic                fold_en;

   assign sel_rdata = mem_rdata[sel_col*BLK_W +: BLK_W];

   rmw_addr_map #(
      .NUM_COLS (NUM_COLS),
      .LBA_W    (LBA_W),
      .STRIPE_W (STRIPE_W),
      .COL_W    (COL_W)
   ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .lba    (wr_lba),
      .stripe (map_stripe),
      .dcol   (map_dcol),
      .pcol   (map_pcol)
   );

   rmw_parity_acc #(
      .BLK_W (BLK_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .fold_en  (fold_en),
      .new_data (data_q),
      .rd_data  (sel_rdata),
      .acc      (par_acc)
   );

   rmw_seq #(
      .NUM_COLS (NUM_COLS),
      .BLK_W    (BLK_W),
      .STRIPE_W (STRIPE_W),
      .COL_W    (COL_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .map_stripe (map_stripe),
      .map_dcol   (map_dcol),
      .map_pcol   (map_pcol),
      .mem_ack    (mem_ack),
      .par_acc    (par_acc),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .sel_col    (sel_col),
      .data_q     (data_q),
      .load_en    (load_en),
      .fold_en    (fold_en),
      .busy       (busy),
      .done       (done)
   );

   // R2
   we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (|mem_req));

endmodule

// File: tb/rmw_parity_ctrl_test.sv
`timescale 1ns/1ps
module rmw_parity_ctrl_test;

   localparam int NC    = 5;
   localparam int BW    = 8;
   localparam int LW    = 6;
   localparam int SW    = 4;
   localparam int DEPTH = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_valid = 1'b0;
   logic [LW-1:0]   wr_lba = '0;
   logic [BW-1:0]   wr_data = '0;
   logic            busy, done, mem_we;
   logic [NC-1:0]   mem_req;
   logic [SW-1:0]   mem_addr;
   logic [BW-1:0]   mem_wdata;
   logic [NC-1:0]   mem_ack = '0;
   logic [NC*BW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   logic [BW-1:0] disk [NC][DEPTH];
   logic [BW-1:0] expm [NC][DEPTH];
   int cnt [NC];
   int lat [NC];
   int log_n = 0;
   int log_col [64];
   int log_we  [64];
   int log_adr [64];
   int log_wd  [64];

   always #2.5 clk = ~clk;

   rmw_parity_ctrl #(.NUM_COLS(NC), .BLK_W(BW), .LBA_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_lba(wr_lba), .wr_data(wr_data),
      .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [BW-1:0] data_init(int c, int a);
      return BW'(c * 37 + a * 11 + 5);
   endfunction

   function automatic int par_col(int s);
      return NC - 1 - (s % NC);
   endfunction

   function automatic logic [BW-1:0] cell_init(int c, int a);
      logic [BW-1:0] x = '0;
      if (c != par_col(a)) return data_init(c, a);
      for (int k = 0; k < NC; k++) if (k != c) x ^= data_init(k, a);
      return x;
   endfunction

   // Column memory models with per-column latency
   always @(posedge clk) begin
      for (int c = 0; c < NC; c++) begin
         mem_ack[c] <= 1'b0;
         if (!rst_n) begin
            cnt[c] = 0;
            for (int a = 0; a < DEPTH; a++) disk[c][a] <= cell_init(c, a);
         end else if (mem_req[c] && !mem_ack[c]) begin
            if (cnt[c] >= lat[c]) begin
               cnt[c] = 0;
               mem_ack[c] <= 1'b1;
               if (mem_we) disk[c][mem_addr] <= mem_wdata;
               else mem_rdata[c*BW +: BW] <= disk[c][mem_addr];
               if (log_n < 64) begin
                  log_col[log_n] = c;
                  log_we[log_n]  = int'(mem_we);
                  log_adr[log_n] = int'(mem_addr);
                  log_wd[log_n]  = int'(mem_wdata);
               end
               log_n = log_n + 1;
            end else begin
               cnt[c] = cnt[c] + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic scan_array(input string tag);
      int bad = 0;
      int badx = 0;
      for (int a = 0; a < DEPTH; a++) begin
         logic [BW-1:0] x = '0;
         for (int c = 0; c < NC; c++) begin
            if (disk[c][a] !== expm[c][a]) bad++;
            x ^= disk[c][a];
         end
         if (x != '0) badx++;
      end
      chk(bad == 0, "R9", {tag, " blocks differing from expected"}, bad, 0);
      chk(badx == 0, "R4", {tag, " stripes with nonzero XOR"}, badx, 0);
   endtask

   // One full write; refuse=1 keeps wr_valid high with another address during busy
   task automatic do_write(input int lba, input int data, input bit refuse, input string tag);
      int s, k, pc, dc, start, waited;
      logic [BW-1:0] np;
      s  = lba / (NC - 1);
      k  = lba % (NC - 1);
      pc = par_col(s);
      dc = (k >= pc) ? k + 1 : k;
      np = expm[dc][s] ^ BW'(data) ^ expm[pc][s];
      expm[dc][s] = BW'(data);
      expm[pc][s] = np;
      start = log_n;
      @(negedge clk);
      wr_valid = 1'b1;
      wr_lba   = LW'(lba);
      wr_data  = BW'(data);
      @(negedge clk);
      wr_lba  = LW'((lba + 13) % 64);
      wr_data = BW'(data ^ 8'h5a);
      wr_valid = refuse;
      chk(busy === 1'b1, "R6", {tag, " busy after accept"}, int'(busy), 1);
      waited = 0;
      while (done !== 1'b1 && waited < 400) begin
         wr_valid = refuse && busy;
         @(negedge clk);
         waited++;
      end
      wr_valid = 1'b0;
      chk(waited < 400, "R6", {tag, " done pulse seen"}, waited, 0);
      chk(busy === 1'b0, "R6", {tag, " busy low with done"}, int'(busy), 0);
      chk(log_n - start == 4, "R2", {tag, " access count"}, log_n - start, 4);
      if (log_n - start >= 4 && log_n <= 64) begin
         chk(log_col[start] == dc && log_we[start] == 0 && log_adr[start] == s,
             "R3", {tag, " step1 data read column"}, log_col[start], dc);
         chk(log_col[start+1] == pc && log_we[start+1] == 0 && log_adr[start+1] == s,
             "R3", {tag, " step2 parity read column"}, log_col[start+1], pc);
         chk(log_col[start+2] == dc && log_we[start+2] == 1 && log_wd[start+2] == data,
             "R1", {tag, " step3 data write value"}, log_wd[start+2], data);
         chk(log_col[start+3] == pc && log_we[start+3] == 1 && log_adr[start+3] == s,
             "R3", {tag, " step4 parity write column"}, log_col[start+3], pc);
         chk(log_wd[start+3] == int'(np), "R4", {tag, " new parity value"}, log_wd[start+3], int'(np));
      end
      @(negedge clk);
      chk(done === 1'b0, "R6", {tag, " done is one cycle"}, int'(done), 0);
      chk(log_n - start == 4 && busy === 1'b0, "R7", {tag, " no later start"}, log_n - start, 4);
      scan_array(tag);
   endtask

   task automatic t_reset;
      chk(busy === 1'b0 && done === 1'b0, "R8", "busy/done in reset", int'(busy) + int'(done), 0);
      chk(mem_req === '0, "R8", "mem_req in reset", int'(mem_req), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && mem_req === '0, "R8", "idle after reset", int'(mem_req), 0);
   endtask

   task automatic t_rotation;
      do_write(0, 8'h3c, 1'b0, "R1 stripe0 slot0");
      do_write(7, 8'ha1, 1'b0, "R1 stripe1 slot past parity");
      do_write(5, 8'h17, 1'b0, "R1 stripe1 slot before parity");
      do_write(19, 8'hf0, 1'b0, "R1 stripe4 parity col0");
      do_write(20, 8'h88, 1'b0, "R1 stripe5 wrap");
      do_write(63, 8'h42, 1'b0, "R1 last block");
   endtask

   task automatic t_rewrite;
      do_write(10, 8'h55, 1'b0, "R4 first write");
      do_write(10, 8'haa, 1'b0, "R4 overwrite");
      do_write(10, 8'h00, 1'b0, "R4 zero data");
   endtask

   task automatic t_slow_memory;
      for (int c = 0; c < NC; c++) lat[c] = 3 + 2 * c;
      do_write(33, 8'h9e, 1'b0, "R5 slow columns");
      do_write(46, 8'h61, 1'b0, "R5 slow columns b");
      for (int c = 0; c < NC; c++) lat[c] = c;
   endtask

   task automatic t_refuse;
      do_write(22, 8'h7d, 1'b1, "R7 refuse while busy");
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin
         lat[c] = c;
         for (int a = 0; a < DEPTH; a++) expm[c][a] = cell_init(c, a);
      end
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_rotation();
      t_rewrite();
      t_slow_memory();
      t_refuse();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL R6 watchdog expired: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule